// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Updates

This block drives four independent pulse-width modulated outputs. Software sets it up through a small memory-mapped register port. Each channel has a prescaler that divides the core clock by a power of two, and a 16-bit counter that runs from zero up to its period minus one. A 16-bit compare value, called the low-time count, sets how many counts of each period the output spends at its inactive level. A polarity bit flips the output.

Channels are switched on and off through two global registers, one that sets and one that clears. A third global register reports which channels are running. While a channel is stopped, software writes its low-time and period registers directly. While it runs, software writes a single staging register instead. The value waits there until the counter wraps. It is then moved into either the low-time or the period register, chosen by a mode bit, so a running waveform never shows a torn cycle.

Top module: `pwm_quad`

## Requirements
- R1: A write to address 0x04 starts every channel whose bit in write data bits 3:0 is 1. A write to address 0x08 stops every channel whose bit is 1. Bits that are 0 leave their channels as they were. Address 0x0C reads back the running state of channel n in bit n, with all other bits zero.
- R2: Each access returns its read data on the clock edge that samples the read enable. Channel n occupies addresses 0x200 + n*0x20. Its registers are mode at +0x00, low-time at +0x04, period at +0x08 and staging at +0x10. The mode register keeps only bits 3:0 (prescale select), bit 9 (invert) and bit 10 (staging target). The low-time, period and staging registers keep only bits 15:0. All other bits read as zero, and the start, stop and unmapped addresses read as zero.
- R3: While a channel runs, its counter advances once per prescaled tick from 0 to period-1 and then returns to 0. With invert clear, the output is low while the counter is below the low-time count and high otherwise, so each period holds period minus low-time high cycles.
- R4: With mode bit 9 set, the output is the complement of R3. A stopped channel then rests high.
- R5: A prescale select of s (0 to 10) makes the counter advance once every 2^s clock cycles.
- R6: A running channel with period 0 holds its output at the inactive level (low with invert clear, high with invert set).
- R7: A low-time count greater than or equal to the period holds the output at its inactive level for the whole period.
- R8: Writes to the low-time and period registers take effect at once while the channel is stopped. They are ignored while it runs.
- R9: A value written to the staging register is copied into the period register if mode bit 10 is 1, or into the low-time register if it is 0, on the clock edge where the counter returns to 0. The other register stays unchanged.
- R10: Until that edge, the staged value reads back from the staging register, and the low-time and period registers keep their old values.
- R11: Stopping a channel at once forces its output to the inactive level and clears its counter and prescaler. A restarted channel begins at count 0, so with low-time 2, period 4 and prescale 0 its output reads low, low, high, high, low, and so on, one value per cycle from the start edge.
- R12: After reset, every channel is stopped, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write strobe, one cycle per write |
| ren | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| pwmOut | output | 4 | Waveform output of each channel |

## Verification
The waveform is checked by counting high cycles over windows that cover a whole number of periods. A low-time of 3 in a period of 10 must give exactly 70 percent high. This measure does not depend on the phase and separates an off-by-one in the compare or the wrap from a correct counter. The polarity-inverted pattern and the prescaled pattern (select 2) are counted the same way. That exposes a swapped polarity or a divider that is off by one power. Period 0 and low-time counts at or above the period must give constant outputs. A restart is checked cycle by cycle to show that counting resumes from zero. Staged updates are read back before and after the period boundary for both target settings, which shows that the value is held back and that the right register receives it.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // counter and compare width
  localparam int CNT_W     = 16;
  // prescale select field width and largest honoured select
  localparam int PRE_SEL_W = 4;
  localparam int PRE_MAX   = 10;

  // global register addresses
  localparam int GLB_START = 'h04;
  localparam int GLB_STOP  = 'h08;
  localparam int GLB_STAT  = 'h0C;

  // per-channel window
  localparam int CH_BASE   = 'h200;
  localparam int CH_STRIDE = 'h20;
  localparam int OFF_MODE  = 'h00;
  localparam int OFF_LOW   = 'h04;
  localparam int OFF_PER   = 'h08;
  localparam int OFF_STAGE = 'h10;

  // mode field positions
  localparam int MODE_INV_BIT = 9;
  localparam int MODE_TGT_BIT = 10;

  typedef struct packed {
    logic [PRE_SEL_W-1:0] preSel;
    logic                 invert;
    logic                 tgtPeriod;
  } chMode_t;

  // control-to-datapath strobes per channel
  typedef struct packed {
    logic run;    // channel is enabled
    logic clear;  // stop request this cycle
  } chStrobe_t;
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            wen,
  input  logic                            ren,
  output logic [DATA_W-1:0]               rdata,
  input  logic [NCH-1:0]                  wrap,
  output chStrobe_t [NCH-1:0]             strobe,
  output chMode_t   [NCH-1:0]             mode,
  output logic      [NCH-1:0][CNT_W-1:0]  lowCnt,
  output logic      [NCH-1:0][CNT_W-1:0]  period,
  output logic      [NCH-1:0]             pend,
  output logic      [NCH-1:0]             stageWr
);
  function automatic logic [ADDR_W-1:0] chAddr(input int ch, input int off);
    return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
  endfunction

  logic [NCH-1:0] runQ;
  logic           startHit, stopHit;
  logic [NCH-1:0] modeWr, lowWr, perWr;
  logic [NCH-1:0][CNT_W-1:0] stageQ;
  logic [DATA_W-1:0] rdNext;

  logic unusedWdata;
  assign unusedWdata = ^wdata[DATA_W-1:MODE_TGT_BIT+1];

  assign startHit = wen && (addr == ADDR_W'(GLB_START));
  assign stopHit  = wen && (addr == ADDR_W'(GLB_STOP));

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      modeWr[i]       = wen && (addr == chAddr(i, OFF_MODE));
      lowWr[i]        = wen && (addr == chAddr(i, OFF_LOW));
      perWr[i]        = wen && (addr == chAddr(i, OFF_PER));
      stageWr[i]      = wen && (addr == chAddr(i, OFF_STAGE));
      strobe[i].run   = runQ[i];
      strobe[i].clear = stopHit && wdata[i];
    end
  end

  // global run state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= '0;
    end else if (startHit) begin
      runQ <= runQ | wdata[NCH-1:0];
    end else if (stopHit) begin
      runQ <= runQ & ~wdata[NCH-1:0];
    end
  end

  // per-channel register file and staging buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      lowCnt <= '0;
      period <= '0;
      stageQ <= '0;
      pend   <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (modeWr[i]) begin
          mode[i].preSel    <= wdata[PRE_SEL_W-1:0];
          mode[i].invert    <= wdata[MODE_INV_BIT];
          mode[i].tgtPeriod <= wdata[MODE_TGT_BIT];
        end
        if (lowWr[i] && !runQ[i]) lowCnt[i] <= wdata[CNT_W-1:0];
        if (perWr[i] && !runQ[i]) period[i] <= wdata[CNT_W-1:0];
        if (wrap[i] && pend[i]) begin
          if (mode[i].tgtPeriod) period[i] <= stageQ[i];
          else                   lowCnt[i] <= stageQ[i];
          pend[i] <= 1'b0;
        end
        if (stageWr[i]) begin
          stageQ[i] <= wdata[CNT_W-1:0];
          pend[i]   <= 1'b1;
        end
      end
    end
  end

  // read mux
  always_comb begin
    rdNext = '0;
    if (addr == ADDR_W'(GLB_STAT)) rdNext[NCH-1:0] = runQ;
    for (int i = 0; i < NCH; i++) begin
      if (addr == chAddr(i, OFF_MODE)) begin
        rdNext[PRE_SEL_W-1:0] = mode[i].preSel;
        rdNext[MODE_INV_BIT]  = mode[i].invert;
        rdNext[MODE_TGT_BIT]  = mode[i].tgtPeriod;
      end
      if (addr == chAddr(i, OFF_LOW))   rdNext[CNT_W-1:0] = lowCnt[i];
      if (addr == chAddr(i, OFF_PER))   rdNext[CNT_W-1:0] = period[i];
      if (addr == chAddr(i, OFF_STAGE)) rdNext[CNT_W-1:0] = stageQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    rdata <= '0;
    else if (ren) rdata <= rdNext;
  end
endmodule

// File: rtl/pwm_quad_dp.sv
module pwm_quad_dp
  import pwm_quad_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  chStrobe_t [NCH-1:0]             strobe,
  input  chMode_t   [NCH-1:0]             mode,
  input  logic      [NCH-1:0][CNT_W-1:0]  lowCnt,
  input  logic      [NCH-1:0][CNT_W-1:0]  period,
  output logic      [NCH-1:0]             wrap,
  output logic      [NCH-1:0][CNT_W-1:0]  cnt,
  output logic      [NCH-1:0]             pwmOut
);
  logic [NCH-1:0] unusedTgt;

  for (genvar g = 0; g < NCH; g++) begin : gCh
    logic [PRE_MAX-1:0]   preQ;
    logic [PRE_MAX-1:0]   preLimit;
    logic [PRE_SEL_W-1:0] selEff;
    logic [CNT_W-1:0]     cntQ;
    logic                 tick, lastCnt, highRaw;

    assign selEff   = (mode[g].preSel > PRE_SEL_W'(PRE_MAX)) ?
                      PRE_SEL_W'(PRE_MAX) : mode[g].preSel;
    assign preLimit = PRE_MAX'((32'd1 << selEff) - 32'd1);
    assign tick     = strobe[g].run && (preQ >= preLimit);
    assign lastCnt  = (period[g] == '0) || (cntQ >= period[g] - CNT_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preQ <= '0;
        cntQ <= '0;
      end else if (strobe[g].clear || !strobe[g].run) begin
        preQ <= '0;
        cntQ <= '0;
      end else if (tick) begin
        preQ <= '0;
        cntQ <= lastCnt ? '0 : cntQ + CNT_W'(1);
      end else begin
        preQ <= preQ + PRE_MAX'(1);
      end
    end

    assign highRaw      = strobe[g].run && (period[g] != '0) && (cntQ >= lowCnt[g]);
    assign pwmOut[g]    = highRaw ^ mode[g].invert;
    assign wrap[g]      = tick && lastCnt;
    assign cnt[g]       = cntQ;
    assign unusedTgt[g] = mode[g].tgtPeriod;
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wen,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwmOut
);
  chStrobe_t [NCH-1:0]            strobe;
  chMode_t   [NCH-1:0]            mode;
  logic      [NCH-1:0][CNT_W-1:0] lowCnt, period, cnt;
  logic      [NCH-1:0]            wrap, pend, stageWr, runVec;

  always_comb begin
    for (int i = 0; i < NCH; i++) runVec[i] = strobe[i].run;
  end

  pwm_quad_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .wen(wen), .ren(ren),
    .rdata(rdata), .wrap(wrap), .strobe(strobe), .mode(mode), .lowCnt(lowCnt),
    .period(period), .pend(pend), .stageWr(stageWr)
  );

  pwm_quad_dp #(.NCH(NCH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .lowCnt(lowCnt),
    .period(period), .wrap(wrap), .cnt(cnt), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NCH-1:0]                 runVec,
  input logic [NCH-1:0]                 wrap,
  input logic [NCH-1:0]                 pend,
  input logic [NCH-1:0]                 stageWr,
  input logic [NCH-1:0][CNT_W-1:0]      cnt,
  input logic [NCH-1:0][CNT_W-1:0]      period,
  input logic [NCH-1:0][CNT_W-1:0]      lowCnt
);
  for (genvar g = 0; g < NCH; g++) begin : gChk
    // R9
    pend_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
      pend[g] && wrap[g] && !stageWr[g] |=> !pend[g]);
    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      pend[g] && !wrap[g] |=> pend[g]);
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !runVec[g] |-> cnt[g] == '0);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      runVec[g] && period[g] != '0 |-> cnt[g] < period[g]);
    // R8
    low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      runVec[g] && !wrap[g] |=> $stable(lowCnt[g]));
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH)) uChk (
  .clk(clk), .rstN(rstN), .runVec(runVec), .wrap(wrap), .pend(pend),
  .stageWr(stageWr), .cnt(cnt), .period(period), .lowCnt(lowCnt)
);

// File: tb/sim_pwm_quad.sv
`timescale 1ns/100ps
module sim_pwm_quad;
  localparam int CHB = 'h200;
  localparam int CHS = 'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic        ren = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwmOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_quad u0 (.clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .wen(wen),
               .ren(ren), .rdata(rdata), .pwmOut(pwmOut));

  function automatic logic [11:0] ra(input int ch, input int off);
    return 12'(CHB + ch * CHS + off);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(posedge clk);
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; ren = 1'b1;
    @(posedge clk);
    @(negedge clk); ren = 1'b0; d = rdata;
  endtask

  task automatic countHigh(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwmOut[ch]) hi++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R12 outputs", {28'd0, pwmOut}, 32'd0);
    busRead(12'h00C, d); check("R12 status", d, 32'd0);
    busRead(ra(0, 'h0), d); check("R12 mode", d, 32'd0);
    busRead(ra(1, 'h8), d); check("R12 period", d, 32'd0);
  endtask

  task automatic testEnable();
    logic [31:0] d;
    busWrite(12'h004, 32'h5); busRead(12'h00C, d); check("R1 start 0101", d, 32'h5);
    busWrite(12'h004, 32'h0); busRead(12'h00C, d); check("R1 zero start", d, 32'h5);
    busWrite(12'h008, 32'h4); busRead(12'h00C, d); check("R1 stop bit2", d, 32'h1);
    busWrite(12'h008, 32'h0); busRead(12'h00C, d); check("R1 zero stop", d, 32'h1);
    busWrite(12'h004, 32'hF); busRead(12'h00C, d); check("R1 all on", d, 32'hF);
    busWrite(12'h008, 32'hF); busRead(12'h00C, d); check("R1 all off", d, 32'h0);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    busWrite(ra(1, 'h0), 32'hFFFF_FFFF); busRead(ra(1, 'h0), d);
    check("R2 mode mask", d, 32'h60F);
    busWrite(ra(1, 'h0), 32'h0);
    busWrite(ra(2, 'h4), 32'hABCD_1234); busRead(ra(2, 'h4), d);
    check("R2 low-time mask", d, 32'h1234);
    busRead(12'h004, d); check("R2 start reads zero", d, 32'h0);
    busRead(12'h100, d); check("R2 unmapped", d, 32'h0);
  endtask

  task automatic testDuty();
    logic [31:0] d; int hi;
    busWrite(ra(0, 'h8), 32'd10); busWrite(ra(0, 'h4), 32'd3);
    busRead(ra(0, 'h8), d); check("R8 direct period", d, 32'd10);
    busWrite(12'h004, 32'h1); idle(12);
    countHigh(0, 40, hi); check("R3 high count 3/10", hi, 32'd28);
    busWrite(ra(0, 'h4), 32'd6); busRead(ra(0, 'h4), d);
    check("R8 ignored while running", d, 32'd3);
    countHigh(0, 40, hi); check("R8 waveform unchanged", hi, 32'd28);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic testPolarity();
    int hi;
    busWrite(ra(1, 'h0), 32'h200);
    busWrite(ra(1, 'h8), 32'd8); busWrite(ra(1, 'h4), 32'd2);
    check("R4 stopped rests high", pwmOut[1], 1);
    busWrite(12'h004, 32'h2); idle(10);
    countHigh(1, 32, hi); check("R4 inverted high count", hi, 32'd8);
    busWrite(12'h008, 32'h2);
    check("R11 stop forces inactive high", pwmOut[1], 1);
  endtask

  task automatic testPrescale();
    int hi;
    busWrite(ra(2, 'h0), 32'h2);
    busWrite(ra(2, 'h8), 32'd5); busWrite(ra(2, 'h4), 32'd1);
    busWrite(12'h004, 32'h4); idle(25);
    countHigh(2, 60, hi); check("R5 prescale 4 high count", hi, 32'd48);
    countHigh(2, 20, hi); check("R5 one divided period", hi, 32'd16);
    busWrite(12'h008, 32'h4);
  endtask

  task automatic testZeroPeriod();
    int hi;
    busWrite(ra(0, 'h8), 32'd0); busWrite(ra(0, 'h4), 32'd0);
    busWrite(ra(1, 'h8), 32'd0);
    busWrite(12'h004, 32'h3); idle(3);
    countHigh(0, 30, hi); check("R6 period 0 normal", hi, 32'd0);
    countHigh(1, 30, hi); check("R6 period 0 inverted", hi, 32'd30);
    busWrite(12'h008, 32'h3);
  endtask

  task automatic testFullDuty();
    int hi;
    busWrite(ra(0, 'h8), 32'd6); busWrite(ra(0, 'h4), 32'd6);
    busWrite(12'h004, 32'h1); idle(3);
    countHigh(0, 36, hi); check("R7 low-time equal period", hi, 32'd0);
    busWrite(12'h008, 32'h1);
    busWrite(ra(0, 'h4), 32'd9);
    busWrite(12'h004, 32'h1); idle(3);
    countHigh(0, 36, hi); check("R7 low-time above period", hi, 32'd0);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic testRestart();
    logic exp [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    busWrite(ra(0, 'h8), 32'd4); busWrite(ra(0, 'h4), 32'd2);
    busWrite(12'h004, 32'h1); idle(7);
    busWrite(12'h008, 32'h1);
    check("R11 stop forces low", pwmOut[0], 0);
    busWrite(12'h004, 32'h1);
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R11 restart cycle %0d", k), pwmOut[0], exp[k]);
      @(negedge clk);
    end
    busWrite(12'h008, 32'h1);
  endtask

  task automatic testStaged();
    logic [31:0] d; int hi;
    busWrite(ra(3, 'h0), 32'h0);
    busWrite(ra(3, 'h4), 32'd100); busWrite(ra(3, 'h8), 32'd1000);
    busWrite(12'h004, 32'h8);
    busWrite(ra(3, 'h10), 32'hFFFF_01F4);
    busRead(ra(3, 'h4), d); check("R10 low-time held", d, 32'd100);
    busRead(ra(3, 'h10), d); check("R10 staged readback", d, 32'd500);
    idle(1100);
    busRead(ra(3, 'h4), d); check("R9 low-time applied", d, 32'd500);
    busRead(ra(3, 'h8), d); check("R9 period untouched", d, 32'd1000);
    countHigh(3, 2000, hi); check("R9 new waveform", hi, 32'd1000);
    busWrite(ra(3, 'h0), 32'h400);
    busWrite(ra(3, 'h10), 32'd40);
    busRead(ra(3, 'h8), d); check("R10 period held", d, 32'd1000);
    idle(1100);
    busRead(ra(3, 'h8), d); check("R9 period applied", d, 32'd40);
    busRead(ra(3, 'h4), d); check("R9 low-time untouched", d, 32'd500);
    busWrite(ra(3, 'h0), 32'h0);
    busWrite(ra(3, 'h10), 32'd10);
    idle(60);
    countHigh(3, 400, hi); check("R9 short period waveform", hi, 32'd300);
    busWrite(12'h008, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testReadback();
    testDuty();
    testPolarity();
    testPrescale();
    testZeroPeriod();
    testFullDuty();
    testRestart();
    testStaged();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule